// File: doc/BRIEF.md
# Pipelined Bitonic Key Sorter

This block sorts a vector of N = 2^K unsigned keys, each W bits wide, that arrives all at once on a single wide input word qualified by a valid flag. The keys pass through a fixed pipeline of compare-and-exchange layers built by recursive bitonic merging. Each layer is registered, so a sorted vector leaves the block exactly K(K+1)/2 cycles after it entered, and a new vector may enter on every cycle. Lane i of any vector word occupies bits [i*W +: W].

The comparator wiring is decided entirely at elaboration. Every layer holds N/2 cells, and no path through the network depends on key values. A direction bit travels with each vector and selects ascending or descending order for that vector alone. A lane-count input lets a shorter list share the hardware. Lanes whose index is at or above that count are replaced by a pad value that always sorts to the tail of the output.

Top module: `bitonic_sorter`

## Requirements
- R1: With N = 2^LOG_N lanes, a vector sampled with `in_valid` high appears on `out_keys` with `out_valid` high exactly LOG_N*(LOG_N+1)/2 clock cycles later (6 cycles for LOG_N = 3).
- R2: A vector is accepted on every cycle that `in_valid` is high, with no stall. Back-to-back vectors leave in the order they entered, one per cycle.
- R3: When `descend` was 0 for a vector, its output is ascending: the key in lane 0 is the smallest, and keys never decrease as the lane index rises.
- R4: When `descend` was 1 for a vector, its output is descending: the key in lane 0 is the largest, and keys never increase as the lane index rises. `out_descend` repeats the direction bit of the vector on `out_keys`.
- R5: The output keys are a permutation of the padded input keys. Duplicate, extreme (all-zero, all-ones) and mixed keys are neither lost nor altered.
- R6: A lane whose index is greater than or equal to `in_count` is replaced before sorting. The replacement is all ones for ascending order and zero for descending order, so pads collect at the highest lane indices. `in_count` of N or more pads nothing. `in_count` of 0 pads every lane.
- R7: The synchronous active-high `rst` clears the valid pipeline. `out_valid` is low during reset, and vectors in flight when reset is asserted never appear on the output.
- R8: A cycle with `in_valid` low produces no output vector. `out_valid` is high only for vectors that were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Input vector qualifier |
| in_keys | input | N*W | Input keys, lane i at bits [i*W +: W] |
| in_count | input | LOG_N+1 | Number of live lanes; lanes at or above it are padded |
| descend | input | 1 | 1 selects descending order for this vector |
| out_valid | output | 1 | Output vector qualifier |
| out_keys | output | N*W | Sorted keys, lane i at bits [i*W +: W] |
| out_descend | output | 1 | Direction bit of the vector on out_keys |

## Verification
The bound checker checks the ordering of every valid output vector on each cycle, in the direction its `out_descend` bit reports. It also checks that the count of vectors in flight never goes above the pipeline depth, that no output appears when nothing is in flight, and that the output is quiet on the cycle reset is released. Exact latency, the permutation property and the pad values that depend on `in_count` can only be shown by the bench. The bench compares each output against an arithmetic model across an exhaustive zero-one sweep in both directions, a sweep over every lane count, runs with gaps between vectors, and a reset that lands while vectors are in flight.

// File: rtl/bsort_pkg.sv
package bsort_pkg;
  // Number of registered comparator layers for 2^k lanes.
  function automatic int layer_count(input int k);
    return k * (k + 1) / 2;
  endfunction

  // Position of merge step t (0 = widest) of building stage s (1-based).
  function automatic int layer_pos(input int s, input int t);
    return s * (s - 1) / 2 + t;
  endfunction
endpackage

// File: rtl/bsort_cas.sv
module bsort_cas #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         flip_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  logic swap;

  // Without flip the lower lane keeps the minimum; with flip it keeps the maximum.
  always_comb begin
    swap = flip_i ? (a_i < b_i) : (a_i > b_i);
    lo_o = swap ? b_i : a_i;
    hi_o = swap ? a_i : b_i;
  end
endmodule

// File: rtl/bsort_pad.sv
module bsort_pad #(
  parameter int LOG_N = 3,
  parameter int W     = 8
) (
  input  logic [(1<<LOG_N)*W-1:0] keys_i,
  input  logic [LOG_N:0]          count_i,
  input  logic                    desc_i,
  output logic [(1<<LOG_N)*W-1:0] keys_o
);
  localparam int N     = 1 << LOG_N;
  localparam int CNT_W = LOG_N + 1;

  logic [W-1:0] pad_val;
  assign pad_val = desc_i ? {W{1'b0}} : {W{1'b1}};

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign keys_o[i*W +: W] = (CNT_W'(i) >= count_i) ? pad_val : keys_i[i*W +: W];
  end
endmodule

// File: rtl/bsort_layer.sv
module bsort_layer #(
  parameter int LOG_N = 3,
  parameter int W     = 8,
  parameter int STEP  = 0,  // pair distance is 2^STEP
  parameter int RUN   = 1   // index bit choosing the run direction
) (
  input  logic                    clk,
  input  logic [(1<<LOG_N)*W-1:0] keys_i,
  input  logic                    desc_i,
  output logic [(1<<LOG_N)*W-1:0] keys_o,
  output logic                    desc_o
);
  localparam int N    = 1 << LOG_N;
  localparam int DIST = 1 << STEP;

  logic [N*W-1:0] nxt;

  for (genvar i = 0; i < N; i++) begin : g_lane
    if (((i >> STEP) & 1) == 0) begin : g_pair
      localparam bit UP = (((i >> RUN) & 1) == 0);
      logic [W-1:0] lo, hi;
      bsort_cas #(.W(W)) u_cas (
        .a_i   (keys_i[i*W +: W]),
        .b_i   (keys_i[(i+DIST)*W +: W]),
        .flip_i(desc_i ^ !UP),
        .lo_o  (lo),
        .hi_o  (hi)
      );
      assign nxt[i*W +: W]        = lo;
      assign nxt[(i+DIST)*W +: W] = hi;
    end
  end

  always_ff @(posedge clk) begin
    keys_o <= nxt;
    desc_o <= desc_i;
  end
endmodule

// File: rtl/bitonic_sorter.sv
module bitonic_sorter
  import bsort_pkg::*;
#(
  parameter int LOG_N = 3,
  parameter int W     = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [(1<<LOG_N)*W-1:0] in_keys,
  input  logic [LOG_N:0]          in_count,
  input  logic                    descend,
  output logic                    out_valid,
  output logic [(1<<LOG_N)*W-1:0] out_keys,
  output logic                    out_descend
);
  localparam int N     = 1 << LOG_N;
  localparam int NW    = N * W;
  localparam int DEPTH = layer_count(LOG_N);

  logic [NW-1:0]    stg_keys [0:DEPTH];
  logic             stg_desc [0:DEPTH];
  logic [DEPTH-1:0] vsr;

  bsort_pad #(.LOG_N(LOG_N), .W(W)) u_pad (
    .keys_i (in_keys),
    .count_i(in_count),
    .desc_i (descend),
    .keys_o (stg_keys[0])
  );
  assign stg_desc[0] = descend;

  for (genvar s = 1; s <= LOG_N; s++) begin : g_stage
    for (genvar t = 0; t < s; t++) begin : g_step
      localparam int L = layer_pos(s, t);
      bsort_layer #(.LOG_N(LOG_N), .W(W), .STEP(s - 1 - t), .RUN(s)) u_layer (
        .clk   (clk),
        .keys_i(stg_keys[L]),
        .desc_i(stg_desc[L]),
        .keys_o(stg_keys[L+1]),
        .desc_o(stg_desc[L+1])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vsr <= '0;
    end else begin
      vsr[0] <= in_valid;
      for (int k = 1; k < DEPTH; k++) vsr[k] <= vsr[k-1];
    end
  end

  assign out_valid   = vsr[DEPTH-1];
  assign out_keys    = stg_keys[DEPTH];
  assign out_descend = stg_desc[DEPTH];
endmodule

// File: rtl/bsort_chk.sv
module bsort_chk #(
  parameter int LOG_N = 3,
  parameter int W     = 8,
  parameter int DEPTH = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic                    out_descend,
  input logic [(1<<LOG_N)*W-1:0] out_keys
);
  localparam int N  = 1 << LOG_N;
  localparam int CW = $clog2(DEPTH + 2) + 1;

  logic [CW-1:0] inflight;
  logic          asc_ok, dsc_ok;

  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + CW'(in_valid) - CW'(out_valid);
  end

  always_comb begin
    asc_ok = 1'b1;
    dsc_ok = 1'b1;
    for (int i = 0; i + 1 < N; i++) begin
      if (out_keys[i*W +: W] > out_keys[(i+1)*W +: W]) asc_ok = 1'b0;
      if (out_keys[i*W +: W] < out_keys[(i+1)*W +: W]) dsc_ok = 1'b0;
    end
  end

  assert_inflight_bound_R1: assert property (@(posedge clk) disable iff (rst)
    inflight <= CW'(DEPTH));

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (inflight != '0));

  assert_ascending_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_descend) |-> asc_ok);

  assert_descending_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_descend) |-> dsc_ok);

  assert_quiet_after_reset_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid);
endmodule

bind bitonic_sorter bsort_chk #(.LOG_N(LOG_N), .W(W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_descend(out_descend),
  .out_keys   (out_keys)
);

// File: tb/tb_bitonic_sorter.sv
module tb_bitonic_sorter;
  localparam int LOG_N = 3;
  localparam int W     = 8;
  localparam int N     = 1 << LOG_N;
  localparam int NW    = N * W;
  localparam int DEPTH = LOG_N * (LOG_N + 1) / 2;
  localparam int QD    = 2048;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [NW-1:0]  in_keys = '0;
  logic [LOG_N:0] in_count = '0;
  logic           descend = 1'b0;
  logic           out_valid;
  logic [NW-1:0]  out_keys;
  logic           out_descend;

  always #4 clk = ~clk;

  bitonic_sorter #(.LOG_N(LOG_N), .W(W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_keys(in_keys),
    .in_count(in_count), .descend(descend), .out_valid(out_valid),
    .out_keys(out_keys), .out_descend(out_descend)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int wr     = 0;
  int rd     = 0;
  bit flush  = 1'b0;
  bit done   = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  logic [NW-1:0] exp_keys  [QD];
  bit            exp_desc  [QD];
  int            exp_stamp [QD];
  string         exp_tag   [QD];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [NW-1:0] act,
                       input logic [NW-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [NW-1:0] model(input logic [NW-1:0] k, input int cnt, input bit d);
    logic [W-1:0] a [N];
    logic [W-1:0] tmp;
    logic [NW-1:0] r;
    for (int i = 0; i < N; i++) a[i] = (i >= cnt) ? (d ? {W{1'b0}} : {W{1'b1}}) : k[i*W +: W];
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N - 1 - i; j++)
        if (d ? (a[j] < a[j+1]) : (a[j] > a[j+1])) begin
          tmp = a[j]; a[j] = a[j+1]; a[j+1] = tmp;
        end
    for (int i = 0; i < N; i++) r[i*W +: W] = a[i];
    return r;
  endfunction

  function automatic logic [NW-1:0] rnd_vec();
    logic [NW-1:0] v;
    for (int i = 0; i < NW; i += 32) v[i +: 32] = rnd();
    return v;
  endfunction

  task automatic send(input logic [NW-1:0] k, input int cnt, input bit d, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_keys  = k;
    in_count = (LOG_N+1)'(cnt);
    descend  = d;
    exp_keys[wr]  = model(k, cnt, d);
    exp_desc[wr]  = d;
    exp_stamp[wr] = cyc;
    exp_tag[wr]   = tag;
    wr++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_keys  = rnd_vec();   // garbage while idle must not appear (R8)
      descend  = rnd()[0];
    end
  endtask

  // Output monitor: every output is matched to the oldest pending vector.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (flush) begin
        rd = wr;
      end else if (out_valid) begin
        if (rd == wr) begin
          check(1'b0, "R8 (output with nothing pending)", out_keys, '0);
        end else begin
          check(out_keys == exp_keys[rd], exp_tag[rd], out_keys, exp_keys[rd]);
          check(out_descend == exp_desc[rd], "R4 (out_descend)",
                NW'(out_descend), NW'(exp_desc[rd]));
          check(cyc - exp_stamp[rd] == DEPTH, "R1 (latency)",
                NW'(cyc - exp_stamp[rd]), NW'(DEPTH));
          rd++;
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [NW-1:0] v;
    // Reset state (R7)
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R7 (valid low in reset)", NW'(out_valid), '0);
    end
    @(negedge clk);
    rst = 1'b0;

    // Exhaustive zero-one sweep, back to back: ascending (R3), then descending (R4)
    for (int d = 0; d < 2; d++) begin
      for (int p = 0; p < (1 << N); p++) begin
        v = '0;
        for (int i = 0; i < N; i++) v[i*W] = p[i];
        send(v, N, d[0], d[0] ? "R4 (zero-one descending)" : "R3 (zero-one ascending)");
      end
    end
    idle(DEPTH + 2);
    check(rd == wr, "R2 (all back-to-back vectors emerged)", NW'(rd), NW'(wr));

    // Every lane count in both directions, plus counts above N (R6)
    for (int c = 0; c <= 2 * N - 1; c++)
      for (int d = 0; d < 2; d++)
        send(rnd_vec(), c, d[0], "R6 (padding by lane count)");

    // Random keys with random direction and gaps (R5, R8)
    for (int n = 0; n < 300; n++) begin
      send(rnd_vec(), N, rnd()[0], "R5 (random keys)");
      if (rnd()[1:0] == 2'b00) idle(int'(rnd()[2:0]) + 1);
    end

    // Duplicates and extremes (R5)
    send({N{8'h5a}}, N, 1'b0, "R5 (all equal)");
    send({N/2{8'hff, 8'h00}}, N, 1'b0, "R5 (extremes ascending)");
    send({N/2{8'h00, 8'hff}}, N, 1'b1, "R5 (extremes descending)");
    send({N/4{8'h80, 8'h80, 8'h7f, 8'h01}}, N, 1'b1, "R5 (duplicate mix)");
    send({N{8'hff}}, 3, 1'b0, "R6 (all-ones keys with pads)");
    idle(DEPTH + 2);
    check(rd == wr, "R2 (all vectors emerged)", NW'(rd), NW'(wr));

    // Reset with vectors in flight (R7)
    send(rnd_vec(), N, 1'b0, "R7 (dropped)");
    send(rnd_vec(), N, 1'b1, "R7 (dropped)");
    idle(1);
    @(negedge clk);
    rst   = 1'b1;
    flush = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < DEPTH + 3; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R7 (in-flight vectors flushed)", NW'(out_valid), '0);
    end
    flush = 1'b0;

    // Pipeline works again after reset (R1)
    send({8'h03, 8'h09, 8'h01, 8'h07, 8'h02, 8'h08, 8'h04, 8'h06}, N, 1'b0,
         "R1 (first vector after reset)");
    idle(DEPTH + 2);
    check(rd == wr, "R1 (vector after reset emerged)", NW'(rd), NW'(wr));
    finish_run();
  end
endmodule